// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter with Channel Chaining

This block is the control core that sits in front of four DMA channel engines and decides which of them may use the shared bus and when each one runs. A channel becomes pending when software pulses its start input. It also becomes pending when its peripheral request is high while that channel's request enable is set. A third cause is a chaining pulse from another channel. Pending state is kept in one flag per channel until that channel is granted, so repeated requests fold into a single service. The channel datapaths (addresses, byte counters, data movement) live outside the block. They report back with a per-transfer completion strobe and a count-zero flag.

Whenever the bus is free, a fixed-priority picker grants the lowest-numbered pending channel, so channel 0 wins over all others. A grant is held until the owner finishes. A cycle-stealing channel gives up the bus after a single transfer. A greedy channel keeps it until the transfer on which its count reaches zero. Grants are never taken away in the middle of that work. When a granted channel completes a transfer, its two-bit chaining mode and two 2-bit target fields can raise a pending request on another channel. The target can be a first channel after each cycle-steal transfer, a second channel at end of count, or either case alone.

Top module: `dma_link_arbiter`

## Requirements
- R1: While reset is low and on the first cycles after it, `grant` is all zero and no channel is pending; a channel is granted only after a later request.
- R2: A one-cycle `sw_start[i]` sampled at rising edge E makes the channel pending at E. If the bus is free, `grant` becomes one-hot with bit i set at edge E+1.
- R3: `periph_req[i]` makes channel i pending only when `req_en[i]` is 1. With `req_en[i]` at 0 the request is dropped and no grant follows.
- R4: When the bus is free and channels are pending, the channel with the lowest index is granted. `grant` never has more than one bit set.
- R5: A grant is never preempted. While a channel holds the bus and has not released it, `grant` stays unchanged even if a higher-priority channel becomes pending.
- R6: The owner releases the bus at the edge after `xfer_done[i]` when `cycle_steal[i]` is 1 (one transfer per grant) or when `count_zero[i]` is 1. Otherwise a greedy channel keeps the bus. After a release, the next pending channel is granted one edge later.
- R7: Any number of requests for a channel that arrive while it is already pending, in the same cycle or in later cycles, produce exactly one grant.
- R8: Chaining mode is `link_mode[2i+1:2i]`, and mode 00 raises no chained request. A chained request makes its target pending one edge after the completing edge. The target is then granted one further edge later if the bus is free.
- R9: Mode 10 makes channel `link_ch1[2i+1:2i]` pending after every transfer of channel i done while `cycle_steal[i]` is 1, including the final one. It does nothing for greedy transfers.
- R10: Mode 01 makes `link_ch1` pending after a cycle-steal transfer whose `count_zero` is 0. It makes `link_ch2[2i+1:2i]` pending, and not `link_ch1`, after the transfer whose `count_zero` is 1.
- R11: Mode 11 makes `link_ch1` pending only after the transfer whose `count_zero` is 1, whether the channel is greedy or cycle-stealing.
- R12: `xfer_done` and `count_zero` of a channel that does not hold the grant are ignored. They neither change the grant nor raise a chained request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_start | input | 4 | Per-channel software start pulse |
| periph_req | input | 4 | Per-channel peripheral request |
| req_en | input | 4 | Per-channel peripheral request enable |
| cycle_steal | input | 4 | Per channel: 1 = one transfer per grant, 0 = greedy |
| link_mode | input | 8 | Per-channel chaining mode, bits [2i+1:2i] |
| link_ch1 | input | 8 | Per-channel first chaining target, bits [2i+1:2i] |
| link_ch2 | input | 8 | Per-channel second chaining target, bits [2i+1:2i] |
| xfer_done | input | 4 | Per-channel one-transfer-complete strobe from the engine |
| count_zero | input | 4 | Per-channel flag: the completing transfer brought the count to zero |
| grant | output | 4 | One-hot bus grant, bit i = channel i |

## Verification
The priority picker is driven from a table of start patterns: single software starts on the top and bottom channels, gated and ungated peripheral requests, mixed software and peripheral sets, and all four channels at once. Each pattern checks both the first channel granted and the total number of grants while the bus is drained. The first result tells priority order apart from arrival order. The grant count tells merged requests apart from duplicated ones, and enabled requests apart from masked ones. Directed cases then tell the four chaining modes apart by the exact edge at which the target is granted and by which target it is, each after an intermediate and after a final transfer. They also separate a greedy owner from a cycle-stealing one, and an owner's strobes from strobes on idle channels.

// File: rtl/dma_link_pkg.sv
// Shared types for the DMA arbiter and chaining logic.
// Assumes the chaining mode field is two bits wide per channel.
package dma_link_pkg;

    // Chaining behaviour selected per channel
    typedef enum logic [1:0] {
        LINK_OFF   = 2'b00,  // never chain
        LINK_SPLIT = 2'b01,  // first target per steal, second target at count zero
        LINK_STEAL = 2'b10,  // first target after every cycle-steal transfer
        LINK_END   = 2'b11   // first target only at count zero
    } link_mode_e;

    localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/dma_req_latch.sv
// Holds one pending flag per channel.
// A flag is set by a software start, an enabled peripheral request or a
// chaining pulse, and cleared when the arbiter takes that channel.
// Assumes that a set arriving in the same cycle as the take must survive,
// so that the new request is served again later.
module dma_req_latch #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sw_start,
    input  logic [NCH-1:0] periph_req,
    input  logic [NCH-1:0] req_en,
    input  logic [NCH-1:0] link_set,
    input  logic [NCH-1:0] take,
    output logic [NCH-1:0] pend_q
);

    logic [NCH-1:0] set_vec;

    // Combine every request source; peripheral requests are gated by enable
    always_comb begin
        set_vec = sw_start | (periph_req & req_en) | link_set;
    end

    // Pending flags: clear on take, set wins over clear, repeats merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~take) | set_vec;
        end
    end

endmodule

// File: rtl/dma_fixed_arb.sv
// Fixed-priority bus arbiter with a registered one-hot grant.
// Arbitrates only while the bus is free; the owner keeps the grant until it
// reports a transfer that ends its tenure (cycle-steal or count zero).
// Assumes xfer_done of a channel that is not the owner carries no meaning.
module dma_fixed_arb #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pend,
    input  logic [NCH-1:0] xfer_done,
    input  logic [NCH-1:0] count_zero,
    input  logic [NCH-1:0] cycle_steal,
    output logic [NCH-1:0] take,
    output logic [NCH-1:0] grant_q
);

    logic           bus_free;
    logic           owner_leaves;
    logic [NCH-1:0] lowest;

    // Isolate the lowest set bit of the pending vector (channel 0 first)
    always_comb begin
        lowest = pend & (~pend + NCH'(1));
    end

    // Bus state and end-of-tenure detection for the current owner
    always_comb begin
        bus_free     = (grant_q == '0);
        owner_leaves = |(grant_q & xfer_done & (cycle_steal | count_zero));
    end

    // Take a new channel only while the bus is free
    always_comb begin
        take = bus_free ? lowest : '0;
    end

    // Grant register: load the winner, hold the owner, drop on release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (take != '0) begin
            grant_q <= take;
        end else if (owner_leaves) begin
            grant_q <= '0;
        end
    end

endmodule

// File: rtl/dma_link_unit.sv
// Decodes the chaining mode of the owning channel on each completed
// transfer and produces a registered one-cycle pulse towards the target
// channels' pending flags.
// Assumes NCH is a power of two so a target field covers all channels.
module dma_link_unit
    import dma_link_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    grant,
    input  logic [NCH-1:0]    xfer_done,
    input  logic [NCH-1:0]    count_zero,
    input  logic [NCH-1:0]    cycle_steal,
    input  logic [NCH*MODE_W-1:0] link_mode,
    input  logic [NCH*CW-1:0] link_ch1,
    input  logic [NCH*CW-1:0] link_ch2,
    output logic [NCH-1:0]    link_q
);

    logic [NCH-1:0] hit_vec [NCH];
    logic [NCH-1:0] hit_any;

    for (genvar g = 0; g < NCH; g++) begin : g_src
        link_mode_e     mode;
        logic           done_own;
        logic           fire1;
        logic           fire2;
        logic [CW-1:0]  tgt1;
        logic [CW-1:0]  tgt2;

        // Per-source field extraction
        always_comb begin
            mode     = link_mode_e'(link_mode[g*MODE_W +: MODE_W]);
            tgt1     = link_ch1[g*CW +: CW];
            tgt2     = link_ch2[g*CW +: CW];
            done_own = grant[g] & xfer_done[g];
        end

        // Mode decode: which of the two targets this completion triggers
        always_comb begin
            fire1 = 1'b0;
            fire2 = 1'b0;
            unique case (mode)
                LINK_OFF: begin
                    fire1 = 1'b0;
                end
                LINK_SPLIT: begin
                    fire1 = done_own & cycle_steal[g] & ~count_zero[g];
                    fire2 = done_own & count_zero[g];
                end
                LINK_STEAL: begin
                    fire1 = done_own & cycle_steal[g];
                end
                LINK_END: begin
                    fire1 = done_own & count_zero[g];
                end
                default: begin
                    fire1 = 1'b0;
                end
            endcase
        end

        // Turn the selected targets into a channel mask
        always_comb begin
            hit_vec[g] = (NCH'(fire1) << tgt1) | (NCH'(fire2) << tgt2);
        end
    end

    // Merge the masks of all sources
    always_comb begin
        hit_any = '0;
        for (int k = 0; k < NCH; k++) begin
            hit_any = hit_any | hit_vec[k];
        end
    end

    // Register the chaining pulse so it lasts exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_q <= '0;
        end else begin
            link_q <= hit_any;
        end
    end

endmodule

// File: rtl/dma_link_arbiter.sv
// Top of the DMA channel arbiter with chaining.
// Collects software, peripheral and chaining requests into pending flags,
// grants the bus to one channel at a time by fixed priority (channel 0
// highest) and chains channels on transfer completion.
// Assumes the channel engines raise xfer_done for one cycle per transfer
// and raise count_zero together with the strobe of the final transfer.
module dma_link_arbiter
    import dma_link_pkg::*;
#(
    parameter int unsigned NCH = 4,
    localparam int unsigned CW = $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            sw_start,
    input  logic [NCH-1:0]            periph_req,
    input  logic [NCH-1:0]            req_en,
    input  logic [NCH-1:0]            cycle_steal,
    input  logic [NCH*MODE_W-1:0]     link_mode,
    input  logic [NCH*CW-1:0]         link_ch1,
    input  logic [NCH*CW-1:0]         link_ch2,
    input  logic [NCH-1:0]            xfer_done,
    input  logic [NCH-1:0]            count_zero,
    output logic [NCH-1:0]            grant
);

    logic [NCH-1:0] pend_q;
    logic [NCH-1:0] take;
    logic [NCH-1:0] grant_q;
    logic [NCH-1:0] link_q;

    dma_req_latch #(.NCH(NCH)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_start   (sw_start),
        .periph_req (periph_req),
        .req_en     (req_en),
        .link_set   (link_q),
        .take       (take),
        .pend_q     (pend_q)
    );

    dma_fixed_arb #(.NCH(NCH)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend_q),
        .xfer_done   (xfer_done),
        .count_zero  (count_zero),
        .cycle_steal (cycle_steal),
        .take        (take),
        .grant_q     (grant_q)
    );

    dma_link_unit #(.NCH(NCH)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant       (grant_q),
        .xfer_done   (xfer_done),
        .count_zero  (count_zero),
        .cycle_steal (cycle_steal),
        .link_mode   (link_mode),
        .link_ch1    (link_ch1),
        .link_ch2    (link_ch2),
        .link_q      (link_q)
    );

    // Drive the grant port from the arbiter register
    always_comb begin
        grant = grant_q;
    end

endmodule

// File: rtl/dma_link_arbiter_chk.sv
// Property checker for dma_link_arbiter, attached by bind.
// Observes the grant port, the owner's strobes, the pending flags and
// the registered chaining pulse.
module dma_link_arbiter_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] grant,
    input logic [NCH-1:0] xfer_done,
    input logic [NCH-1:0] count_zero,
    input logic [NCH-1:0] cycle_steal,
    input logic [NCH-1:0] pend,
    input logic [NCH-1:0] link_q
);

    logic ends_tenure;

    // Owner reports a transfer that ends its hold on the bus
    always_comb begin
        ends_tenure = |(grant & xfer_done & (cycle_steal | count_zero));
    end

    // R1: a reset cycle leaves the bus unowned
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> grant == '0);

    // R4: at most one owner
    p_grant_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R4: a free bus goes to the lowest pending channel
    p_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && pend != '0) |=> grant == ($past(pend) & (~$past(pend) + NCH'(1))));

    // R5: an owner that does not end its tenure keeps the bus
    p_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !ends_tenure) |=> grant == $past(grant));

    // R6: an owner that ends its tenure leaves the bus free
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ends_tenure |=> grant == '0);

    // R8: a chaining pulse leaves its targets pending
    p_link_sets_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_q != '0) |=> (pend & $past(link_q)) == $past(link_q));

endmodule

bind dma_link_arbiter dma_link_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant       (grant),
    .xfer_done   (xfer_done),
    .count_zero  (count_zero),
    .cycle_steal (cycle_steal),
    .pend        (pend_q),
    .link_q      (link_q)
);

// File: tb/test_dma_link_arbiter.sv
// Self-checking bench for dma_link_arbiter: a vector table for the
// priority picker, then directed tests for holding, merging and chaining.
module test_dma_link_arbiter;

    localparam int unsigned NCH = 4;

    typedef struct packed {
        logic [3:0] sw;
        logic [3:0] preq;
        logic [3:0] en;
        logic [3:0] first;
        logic [2:0] cnt;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{4'b0001, 4'b0000, 4'b0000, 4'b0001, 3'd1},
        '{4'b1000, 4'b0000, 4'b0000, 4'b1000, 3'd1},
        '{4'b0000, 4'b0100, 4'b0100, 4'b0100, 3'd1},
        '{4'b0000, 4'b0100, 4'b0000, 4'b0000, 3'd0},
        '{4'b0110, 4'b0000, 4'b0000, 4'b0010, 3'd2},
        '{4'b1000, 4'b0001, 4'b1111, 4'b0001, 3'd2},
        '{4'b0000, 4'b1111, 4'b1010, 4'b0010, 3'd2},
        '{4'b0011, 4'b0011, 4'b0011, 4'b0001, 3'd2},
        '{4'b1111, 4'b0000, 4'b0000, 4'b0001, 3'd4},
        '{4'b0000, 4'b1001, 4'b0001, 4'b0001, 3'd1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] sw_start, periph_req, req_en, cycle_steal;
    logic [7:0] link_mode, link_ch1, link_ch2;
    logic [3:0] xfer_done, count_zero;
    logic [3:0] grant;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_link_arbiter #(.NCH(NCH)) i_dma_link_arbiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_start    (sw_start),
        .periph_req  (periph_req),
        .req_en      (req_en),
        .cycle_steal (cycle_steal),
        .link_mode   (link_mode),
        .link_ch1    (link_ch1),
        .link_ch2    (link_ch2),
        .xfer_done   (xfer_done),
        .count_zero  (count_zero),
        .grant       (grant)
    );

    task automatic check(input logic [3:0] got, input logic [3:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reset with default configuration; returns at a negedge, reset released
    task automatic do_reset();
        rst_n       = 1'b0;
        sw_start    = '0;
        periph_req  = '0;
        req_en      = '0;
        cycle_steal = 4'b1111;
        link_mode   = '0;
        link_ch1    = '0;
        link_ch2    = '0;
        xfer_done   = '0;
        count_zero  = '0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic start(input logic [3:0] m);
        sw_start = m;
        step(1);
        sw_start = '0;
    endtask

    task automatic done(input logic [3:0] m, input logic cz);
        xfer_done  = m;
        count_zero = cz ? m : 4'b0000;
        step(1);
        xfer_done  = '0;
        count_zero = '0;
    endtask

    // Complete every grant with a final transfer and count them
    task automatic drain(output int cnt);
        cnt = 0;
        for (int k = 0; k < 12; k++) begin
            if (grant != '0) begin
                cnt++;
                done(grant, 1'b1);
            end else begin
                step(1);
            end
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n;

        // R1: reset state and no spontaneous grant
        do_reset();
        check(grant, 4'b0000, "R1 after reset");
        step(3);
        check(grant, 4'b0000, "R1 idle after reset");

        // R2 R3 R4 R7: vector table
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            sw_start   = VEC[v].sw;
            periph_req = VEC[v].preq;
            req_en     = VEC[v].en;
            step(1);
            sw_start   = '0;
            periph_req = '0;
            step(1);
            check(grant, VEC[v].first, $sformatf("R2 R3 R4 vector %0d first grant", v));
            drain(n);
            check_int(n, int'(VEC[v].cnt), $sformatf("R3 R7 vector %0d grant count", v));
        end

        // R2: exact edge of the grant
        do_reset();
        start(4'b0100);
        check(grant, 4'b0000, "R2 not yet granted at request edge");
        step(1);
        check(grant, 4'b0100, "R2 granted one edge later");

        // R5: no preemption by a higher channel
        do_reset();
        cycle_steal = 4'b0111;
        start(4'b1000);
        step(1);
        check(grant, 4'b1000, "R5 low channel owns bus");
        start(4'b0001);
        done(4'b1000, 1'b0);
        step(2);
        check(grant, 4'b1000, "R5 greedy owner not preempted");
        done(4'b1000, 1'b1);
        check(grant, 4'b0000, "R6 release at count zero");
        step(1);
        check(grant, 4'b0001, "R5 waiting channel granted after release");

        // R6: greedy holds across transfers, cycle-steal releases after one
        do_reset();
        cycle_steal = 4'b1101;
        start(4'b0010);
        step(1);
        done(4'b0010, 1'b0);
        done(4'b0010, 1'b0);
        check(grant, 4'b0010, "R6 greedy keeps bus");
        done(4'b0010, 1'b1);
        check(grant, 4'b0000, "R6 greedy releases at count zero");
        start(4'b0100);
        step(1);
        done(4'b0100, 1'b0);
        check(grant, 4'b0000, "R6 cycle-steal releases after one transfer");

        // R7: repeated starts while pending merge into one grant
        do_reset();
        cycle_steal = 4'b1110;
        start(4'b0001);
        step(1);
        start(4'b0100);
        start(4'b0100);
        start(4'b0100);
        done(4'b0001, 1'b1);
        step(1);
        check(grant, 4'b0100, "R7 merged channel granted");
        drain(n);
        check_int(n, 1, "R7 exactly one grant for merged requests");

        // R12: strobes of idle channels are ignored
        do_reset();
        cycle_steal = 4'b1101;
        link_mode   = 8'b11_00_00_00;
        link_ch1    = 8'b00_00_00_00;
        start(4'b0010);
        step(1);
        done(4'b1000, 1'b1);
        done(4'b0100, 1'b1);
        step(3);
        check(grant, 4'b0010, "R12 owner unaffected by idle strobes");
        done(4'b0010, 1'b1);
        step(3);
        check(grant, 4'b0000, "R12 no chain from idle channel strobe");

        // R8: mode 00 raises no chained request
        do_reset();
        link_ch1 = 8'b00_00_00_10;
        link_ch2 = 8'b00_00_00_11;
        start(4'b0001);
        step(1);
        done(4'b0001, 1'b1);
        step(4);
        check(grant, 4'b0000, "R8 mode 00 no chain");

        // R9: mode 10, chain after each cycle-steal transfer
        do_reset();
        link_mode = 8'b00_00_00_10;
        link_ch1  = 8'b00_00_00_11;
        start(4'b0001);
        step(1);
        check(grant, 4'b0001, "R9 source granted");
        done(4'b0001, 1'b0);
        check(grant, 4'b0000, "R9 source released");
        step(1);
        check(grant, 4'b0000, "R8 target pending, not yet granted");
        step(1);
        check(grant, 4'b1000, "R9 target granted after intermediate transfer");
        done(4'b1000, 1'b1);
        start(4'b0001);
        step(1);
        done(4'b0001, 1'b1);
        step(2);
        check(grant, 4'b1000, "R9 target granted after final transfer");
        done(4'b1000, 1'b1);
        cycle_steal = 4'b1110;
        start(4'b0001);
        step(1);
        done(4'b0001, 1'b0);
        done(4'b0001, 1'b1);
        step(3);
        check(grant, 4'b0000, "R9 greedy transfers do not chain");

        // R10: mode 01, first target per steal, second at count zero
        do_reset();
        link_mode = 8'b00_00_01_00;
        link_ch1  = 8'b00_00_10_00;
        link_ch2  = 8'b00_00_11_00;
        start(4'b0010);
        step(1);
        done(4'b0010, 1'b0);
        step(2);
        check(grant, 4'b0100, "R10 first target after intermediate transfer");
        drain(n);
        check_int(n, 1, "R10 only first target chained");
        start(4'b0010);
        step(1);
        done(4'b0010, 1'b1);
        step(2);
        check(grant, 4'b1000, "R10 second target at count zero");
        drain(n);
        check_int(n, 1, "R10 first target not chained at count zero");

        // R11: mode 11, chain only at count zero
        do_reset();
        cycle_steal = 4'b1110;
        link_mode   = 8'b00_00_00_11;
        link_ch1    = 8'b00_00_00_10;
        start(4'b0001);
        step(1);
        done(4'b0001, 1'b0);
        step(3);
        check(grant, 4'b0001, "R11 greedy keeps bus, no chain yet");
        done(4'b0001, 1'b1);
        step(2);
        check(grant, 4'b0100, "R11 target granted at count zero");
        drain(n);
        check_int(n, 1, "R11 single chained grant");
        cycle_steal = 4'b1111;
        start(4'b0001);
        step(1);
        done(4'b0001, 1'b0);
        step(4);
        check(grant, 4'b0000, "R11 cycle-steal intermediate transfer does not chain");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule